// File: doc/BRIEF.md
# Indirect Register Access Controller

This block is the host-facing register front end of a network controller. The host uses a synchronous byte-offset bus with separate read and write strobes. It does not address internal registers directly. It first writes a register number into an address port. It then reads or writes one of two data ports. One data port reaches the control/status group; the other reaches a small bank of bus-configuration registers. A fourth offset acts as a reset trigger: a single read of it resets the block.

The control/status group holds the following:
- a command/status word with init, start and stop commands, a global interrupt enable and sticky status flags;
- an interrupt-mask word;
- a mode word;
- a test-enable word;
- a test word, which carries a runt-accept bit and is writable only while the test enable is set.

The block produces only the control outputs that a datapath would consume: transmit/receive enables, init and pointer-reset pulses, a masked interrupt, the mode word, the runt-accept flag, the configuration bank and the soft-reset pulse.

Top module: `indirect_reg_ctrl`

## Requirements
- R1: The address port is at byte offset 0x12 and stores the low 7 bits of the written data, which read back zero-extended. Neither hardware reset, soft reset nor a stop command changes it.
- R2: Data-port accesses use the stored register number. Offset 0x10 reaches the control/status group and offset 0x16 reaches configuration registers 0 to 7. The same number on the two ports names two different registers. Read data appears on `bus_rdata_o` one cycle after the read strobe.
- R3: A read of offset 0x20, with no write, raises `soft_rst_o` for exactly one cycle, starting on the edge after the read. On the following edge every register except the address port returns to its reset value.
- R4: Writing a 1 to bit 2 (stop) of control register 0 has these effects on the same edge:
  - the enables go low;
  - the status bits are cleared;
  - `ptr_rst_o` pulses for one cycle;
  - stop reads back as 1.
  The mode word, mask word, interrupt enable and runt-accept bit are left unchanged.
- R5: In register 0, bit 0 is init and bit 1 is start. A write with both set, and stop clear, does all of the following on that edge:
  - pulses `init_req_o`;
  - sets the init-done status bit (bit 13);
  - raises `tx_en_o` and `rx_en_o`;
  - makes bits 1, 3 and 4 read 1 and bit 2 read 0.
- R6: `irq_o` is high one cycle after the following holds: bit 6 (enable) of register 0 is 1 and at least one status bit is 1 whose mask bit is 0. Bit 7 of register 0 reads that condition directly.
- R7: Register 3 holds one mask bit per status source, in bits 8 to 13. In order these are babble, missed frame, memory error, receive, transmit and init done. All other bits, including the three lowest, read 0 and ignore writes. Register 3 is writable while stopped or running.
- R8: Register 124 (test) takes writes to bit 0 (runt accept) only while bit 0 of register 4 (test enable) is 1. While the enable is 0, register 124 reads 0 and writes leave `runt_accept_o` unchanged.
- R9: Hardware reset clears the runt-accept bit. A stop command does not clear it.
- R10: Status bits 8 to 13 are sticky and cleared by writing 1 to them. A source that is active in the same cycle as the clearing write keeps its bit set. The event inputs, bits 0 to 4 of `event_i`, map to status bits 8 to 12.
- R11: Control/status register numbers other than 0, 3, 4, 15 and 124, and configuration numbers of 8 or more, read 0 and ignore writes.
- R12: After reset the state is as follows:
  - register 0 reads 0x0004;
  - the enables, pulses and `irq_o` are low;
  - mode and configuration registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high hardware reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_ofs_i | input | 6 | Byte offset from the I/O base |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| event_i | input | 5 | Status sources: babble, missed, memory error, receive, transmit |
| tx_en_o | output | 1 | Transmit state machine enable |
| rx_en_o | output | 1 | Receive state machine enable |
| init_req_o | output | 1 | One-cycle init request |
| ptr_rst_o | output | 1 | One-cycle FIFO and descriptor-pointer reset |
| irq_o | output | 1 | Masked, enabled interrupt |
| runt_accept_o | output | 1 | Runt-frame accept flag |
| mode_o | output | 16 | Mode word |
| cfg_o | output | 128 | Configuration bank, register 0 in the low bits |
| soft_rst_o | output | 1 | Soft-reset pulse |

## Verification
Two things can land on the same edge: a host write that clears a status bit, and the datapath event that sets that bit. Directed cases drive a source on the very cycle of the clearing write, and check that the bit survives and the interrupt stays up. Further directed cases issue the write with the source idle, and check that the bit drops. Random traffic then mixes random event vectors with random clear masks and start/init commands in the same writes. A bench model merges these with set-wins priority, and each result is compared on read-back of register 0 and on `irq_o` one cycle later.

// File: rtl/irac_pkg.sv
package irac_pkg;

  // byte offsets of the host ports
  localparam int OFS_CSR  = 'h10;
  localparam int OFS_ADDR = 'h12;
  localparam int OFS_CFG  = 'h16;
  localparam int OFS_SRST = 'h20;

  // control/status register numbers
  localparam int IDX_CTL  = 0;
  localparam int IDX_MASK = 3;
  localparam int IDX_TEN  = 4;
  localparam int IDX_MODE = 15;
  localparam int IDX_TEST = 124;

  // bit positions inside the command/status word
  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_TXON  = 3;
  localparam int B_RXON  = 4;
  localparam int B_IE    = 6;
  localparam int B_IRQ   = 7;
  localparam int B_ST0   = 8;

  // status sources; the init-done flag is the highest one
  localparam int NSRC = 6;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_CSR,
    RS_ADDR,
    RS_CFG
  } rsel_e;

  typedef struct packed {
    logic  csr_we;
    logic  cfg_we;
    logic  addr_we;
    logic  srst_rd;
    rsel_e rsel;
  } port_sel_t;

endpackage

// File: rtl/irac_port_dec.sv
module irac_port_dec
  import irac_pkg::*;
#(
  parameter int AW = 7,
  parameter int OW = 6
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [OW-1:0] bus_ofs_i,
  input  logic [AW-1:0] addr_wdata_i,
  output port_sel_t     sel_o,
  output logic [AW-1:0] addr_o,
  output logic          srst_o
);

  logic [AW-1:0] addr_q;
  logic          srst_q;

  always_comb begin
    sel_o         = '0;
    sel_o.csr_we  = bus_wr_i && (bus_ofs_i == OW'(OFS_CSR));
    sel_o.cfg_we  = bus_wr_i && (bus_ofs_i == OW'(OFS_CFG));
    sel_o.addr_we = bus_wr_i && (bus_ofs_i == OW'(OFS_ADDR));
    sel_o.srst_rd = bus_rd_i && !bus_wr_i && (bus_ofs_i == OW'(OFS_SRST));
    sel_o.rsel    = RS_NONE;
    if (bus_rd_i) begin
      if (bus_ofs_i == OW'(OFS_CSR))       sel_o.rsel = RS_CSR;
      else if (bus_ofs_i == OW'(OFS_ADDR)) sel_o.rsel = RS_ADDR;
      else if (bus_ofs_i == OW'(OFS_CFG))  sel_o.rsel = RS_CFG;
    end
  end

  // address port: deliberately outside every reset
  always_ff @(posedge clk_i) begin
    if (sel_o.addr_we) addr_q <= addr_wdata_i;
  end

  // soft-reset pulse, one cycle after the triggering read
  always_ff @(posedge clk_i) begin
    if (rst_i) srst_q <= 1'b0;
    else       srst_q <= sel_o.srst_rd;
  end

  assign addr_o = addr_q;
  assign srst_o = srst_q;

  AST_SRST_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_rd_i && !bus_wr_i && bus_ofs_i == OW'(OFS_SRST)) |=> srst_o)
    else $error("soft reset pulse missing"); // R3
  AST_ADDR_HOLDS: assert property (@(posedge clk_i)
    !(bus_wr_i && bus_ofs_i == OW'(OFS_ADDR)) |=> $stable(addr_o))
    else $error("address port changed without a write"); // R1

endmodule

// File: rtl/irac_cfg_bank.sv
module irac_cfg_bank #(
  parameter int DW   = 16,
  parameter int AW   = 7,
  parameter int NCFG = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               we_i,
  input  logic [AW-1:0]      idx_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NCFG*DW-1:0] cfg_o
);

  localparam int IW = (NCFG > 1) ? $clog2(NCFG) : 1;

  logic [DW-1:0] bank_q [NCFG];
  logic          hit;
  logic [IW-1:0] slot;

  assign hit  = (idx_i < AW'(NCFG));
  assign slot = idx_i[IW-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NCFG; i++) bank_q[i] <= '0;
    end else if (we_i && hit) begin
      bank_q[slot] <= wdata_i;
    end
  end

  assign rdata_o = hit ? bank_q[slot] : '0;

  for (genvar g = 0; g < NCFG; g++) begin : g_flat
    assign cfg_o[g*DW +: DW] = bank_q[g];
  end

endmodule

// File: rtl/irac_csr_bank.sv
module irac_csr_bank
  import irac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            we_i,
  input  logic [AW-1:0]   idx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-2:0] ev_i,
  output logic [DW-1:0]   rdata_o,
  output logic            tx_en_o,
  output logic            rx_en_o,
  output logic            init_req_o,
  output logic            ptr_rst_o,
  output logic            irq_o,
  output logic            runt_o,
  output logic [DW-1:0]   mode_o
);

  logic            run_q, stopped_q, ie_q, ten_q, runt_q;
  logic            irq_q, init_q, ptr_q;
  logic [NSRC-1:0] st_q, mask_q, st_d, st_clr, st_set;
  logic [DW-1:0]   mode_q;

  logic ctl_we, mask_we, ten_we, mode_we, test_we;
  logic stop_cmd, start_cmd, init_cmd, pend;

  assign ctl_we  = we_i && (idx_i == AW'(IDX_CTL));
  assign mask_we = we_i && (idx_i == AW'(IDX_MASK));
  assign ten_we  = we_i && (idx_i == AW'(IDX_TEN));
  assign mode_we = we_i && (idx_i == AW'(IDX_MODE));
  assign test_we = we_i && (idx_i == AW'(IDX_TEST));

  // stop takes priority over init and start in the same write
  assign stop_cmd  = ctl_we && wdata_i[B_STOP];
  assign start_cmd = ctl_we && wdata_i[B_START] && !stop_cmd;
  assign init_cmd  = ctl_we && wdata_i[B_INIT] && !stop_cmd;

  assign st_clr = ctl_we ? wdata_i[B_ST0 +: NSRC] : '0;
  assign st_set = {init_cmd, ev_i};

  // sticky flags: a set in the same cycle beats the write-one clear
  always_comb begin
    if (stop_cmd) st_d = '0;
    else          st_d = (st_q & ~st_clr) | st_set;
  end

  assign pend = ie_q && |(st_q & ~mask_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q     <= 1'b0;
      stopped_q <= 1'b1;
      ie_q      <= 1'b0;
      st_q      <= '0;
      mask_q    <= '0;
      ten_q     <= 1'b0;
      mode_q    <= '0;
      runt_q    <= 1'b0;
      irq_q     <= 1'b0;
      init_q    <= 1'b0;
      ptr_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      irq_q  <= pend;
      init_q <= init_cmd;
      ptr_q  <= stop_cmd;
      if (stop_cmd) begin
        run_q     <= 1'b0;
        stopped_q <= 1'b1;
      end else if (start_cmd) begin
        run_q     <= 1'b1;
        stopped_q <= 1'b0;
      end
      if (ctl_we)            ie_q   <= wdata_i[B_IE];
      if (mask_we)           mask_q <= wdata_i[B_ST0 +: NSRC];
      if (ten_we)            ten_q  <= wdata_i[0];
      if (mode_we)           mode_q <= wdata_i;
      if (test_we && ten_q)  runt_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == AW'(IDX_CTL)) begin
      rdata_o[B_START]           = run_q;
      rdata_o[B_STOP]            = stopped_q;
      rdata_o[B_TXON]            = run_q;
      rdata_o[B_RXON]            = run_q;
      rdata_o[B_IE]              = ie_q;
      rdata_o[B_IRQ]             = pend;
      rdata_o[B_ST0 +: NSRC]     = st_q;
    end else if (idx_i == AW'(IDX_MASK)) begin
      rdata_o[B_ST0 +: NSRC]     = mask_q;
    end else if (idx_i == AW'(IDX_TEN)) begin
      rdata_o[0]                 = ten_q;
    end else if (idx_i == AW'(IDX_MODE)) begin
      rdata_o                    = mode_q;
    end else if (idx_i == AW'(IDX_TEST)) begin
      rdata_o[0]                 = ten_q && runt_q;
    end
  end

  assign tx_en_o    = run_q;
  assign rx_en_o    = run_q;
  assign init_req_o = init_q;
  assign ptr_rst_o  = ptr_q;
  assign irq_o      = irq_q;
  assign runt_o     = runt_q;
  assign mode_o     = mode_q;

  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_cmd |=> (!tx_en_o && !rx_en_o && ptr_rst_o && st_q == '0))
    else $error("stop did not halt"); // R4
  AST_STOP_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_cmd |=> ($stable(mode_o) && $stable(mask_q) && $stable(runt_o)))
    else $error("stop altered configuration"); // R4
  AST_INIT_START: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_cmd && init_cmd) |=> (init_req_o && tx_en_o && st_q[NSRC-1]))
    else $error("init with start lost one of them"); // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (rst_i)
    !ie_q |=> !irq_o)
    else $error("interrupt while disabled"); // R6
  AST_TEST_LOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
    (test_we && !ten_q) |=> $stable(runt_o))
    else $error("test register written while locked"); // R8

  for (genvar g = 0; g < NSRC-1; g++) begin : g_evt
    AST_EVT_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_i[g] && !stop_cmd) |=> st_q[g])
      else $error("status event lost"); // R10
  end

endmodule

// File: rtl/indirect_reg_ctrl.sv
module indirect_reg_ctrl
  import irac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 7,
  parameter int OW   = 6,
  parameter int NCFG = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [OW-1:0]      bus_ofs_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  input  logic [NSRC-2:0]    event_i,
  output logic               tx_en_o,
  output logic               rx_en_o,
  output logic               init_req_o,
  output logic               ptr_rst_o,
  output logic               irq_o,
  output logic               runt_accept_o,
  output logic [DW-1:0]      mode_o,
  output logic [NCFG*DW-1:0] cfg_o,
  output logic               soft_rst_o
);

  port_sel_t     sel;
  logic [AW-1:0] addr;
  logic          srst;
  logic          rst_int;
  logic [DW-1:0] csr_rdata, cfg_rdata, rdata_q;

  assign rst_int = rst_i || srst;

  irac_port_dec #(.AW(AW), .OW(OW)) u_dec (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_wr_i     (bus_wr_i),
    .bus_rd_i     (bus_rd_i),
    .bus_ofs_i    (bus_ofs_i),
    .addr_wdata_i (bus_wdata_i[AW-1:0]),
    .sel_o        (sel),
    .addr_o       (addr),
    .srst_o       (srst)
  );

  irac_csr_bank #(.DW(DW), .AW(AW)) u_csr (
    .clk_i      (clk_i),
    .rst_i      (rst_int),
    .we_i       (sel.csr_we),
    .idx_i      (addr),
    .wdata_i    (bus_wdata_i),
    .ev_i       (event_i),
    .rdata_o    (csr_rdata),
    .tx_en_o    (tx_en_o),
    .rx_en_o    (rx_en_o),
    .init_req_o (init_req_o),
    .ptr_rst_o  (ptr_rst_o),
    .irq_o      (irq_o),
    .runt_o     (runt_accept_o),
    .mode_o     (mode_o)
  );

  irac_cfg_bank #(.DW(DW), .AW(AW), .NCFG(NCFG)) u_cfg (
    .clk_i   (clk_i),
    .rst_i   (rst_int),
    .we_i    (sel.cfg_we),
    .idx_i   (addr),
    .wdata_i (bus_wdata_i),
    .rdata_o (cfg_rdata),
    .cfg_o   (cfg_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_int) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      unique case (sel.rsel)
        RS_CSR:  rdata_q <= csr_rdata;
        RS_ADDR: rdata_q <= DW'(addr);
        RS_CFG:  rdata_q <= cfg_rdata;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign soft_rst_o  = srst;

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    soft_rst_o |=> (!tx_en_o && mode_o == '0 && !runt_accept_o))
    else $error("soft reset left state behind"); // R3

endmodule

// File: tb/indirect_reg_ctrl_tb_top.sv
module indirect_reg_ctrl_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr = 1'b0, rd = 1'b0;
  logic [5:0]   ofs = '0;
  logic [15:0]  wd = '0;
  logic [4:0]   ev = '0;
  logic [15:0]  rdata, mode;
  logic [127:0] cfg;
  logic         tx_en, rx_en, init_req, ptr_rst, irq, runt, srst;

  always #5 clk = ~clk;

  indirect_reg_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_ofs_i(ofs),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .event_i(ev), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .init_req_o(init_req), .ptr_rst_o(ptr_rst), .irq_o(irq),
    .runt_accept_o(runt), .mode_o(mode), .cfg_o(cfg), .soft_rst_o(srst)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model
  logic [6:0]  m_addr = '0;
  logic [15:0] m_cfg [8];
  logic [15:0] m_mode;
  logic [5:0]  m_st, m_mask;
  logic        m_run, m_stop, m_ie, m_ten, m_runt;

  task automatic mreset();
    for (int i = 0; i < 8; i++) m_cfg[i] = '0;
    m_mode = '0; m_st = '0; m_mask = '0;
    m_run = 0; m_stop = 1; m_ie = 0; m_ten = 0; m_runt = 0;
  endtask

  function automatic logic mpend();
    return m_ie && |(m_st & ~m_mask);
  endfunction

  function automatic logic [15:0] exp_ctl();
    logic [15:0] v = '0;
    v[1] = m_run; v[2] = m_stop; v[3] = m_run; v[4] = m_run;
    v[6] = m_ie; v[7] = mpend(); v[13:8] = m_st;
    return v;
  endfunction

  function automatic logic [15:0] exp_csr(logic [6:0] idx);
    case (idx)
      7'd0:   return exp_ctl();
      7'd3:   return {2'b0, m_mask, 8'h00};
      7'd4:   return {15'b0, m_ten};
      7'd15:  return m_mode;
      7'd124: return {15'b0, m_ten & m_runt};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic mstep(bit cw, logic [15:0] d, logic [4:0] e);
    bit ctl = cw && (m_addr == 7'd0);
    if (ctl && d[2]) begin
      m_st = '0; m_run = 0; m_stop = 1;
    end else begin
      m_st = (m_st & ~(ctl ? d[13:8] : 6'h00)) | {ctl && d[0], e};
      if (ctl && d[1]) begin m_run = 1; m_stop = 0; end
    end
    if (ctl) m_ie = d[6];
    if (cw && m_addr == 7'd3)   m_mask = d[13:8];
    if (cw && m_addr == 7'd4)   m_ten  = d[0];
    if (cw && m_addr == 7'd15)  m_mode = d;
    if (cw && m_addr == 7'd124 && m_ten) m_runt = d[0];
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xact(bit w, bit r, logic [5:0] o, logic [15:0] d, logic [4:0] e);
    @(negedge clk);
    wr = w; rd = r; ofs = o; wd = d; ev = e;
    @(posedge clk);
    #1;
    wr = 0; rd = 0; ev = '0;
    if (w && o == 6'h12) m_addr = d[6:0];
    else begin
      mstep(w && o == 6'h10, d, e);
      if (w && o == 6'h16 && m_addr < 7'd8) m_cfg[m_addr[2:0]] = d;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) xact(0, 0, 6'h00, 16'h0, 5'h0);
  endtask

  task automatic csr_wr(logic [6:0] idx, logic [15:0] d, logic [4:0] e);
    xact(1, 0, 6'h12, {9'b0, idx}, 5'h0);
    xact(1, 0, 6'h10, d, e);
  endtask

  task automatic csr_chk(string tag, logic [6:0] idx);
    xact(1, 0, 6'h12, {9'b0, idx}, 5'h0);
    xact(0, 1, 6'h10, 16'h0, 5'h0);
    chk(tag, rdata, exp_csr(idx));
  endtask

  task automatic hw_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    mreset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [6:0]  ix;
    void'($urandom(32'd20240611));
    mreset();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R12 reset state
    chk("R12 irq", irq, 0);
    chk("R12 tx_en", tx_en, 0);
    chk("R12 srst", srst, 0);
    chk("R12 mode", mode, 0);
    chk("R12 cfg", cfg[31:0], 0);
    csr_chk("R12 ctl", 7'd0);
    chk("R12 ctl value", rdata, 16'h0004);

    // R1 address port survives hardware reset and stop
    xact(1, 0, 6'h12, 16'h000F, 5'h0);
    hw_reset();
    xact(0, 1, 6'h12, 16'h0, 5'h0);
    chk("R1 addr after reset", rdata, 16'h000F);

    // R7 mask bits, written while stopped
    csr_wr(7'd3, 16'hFFFF, 5'h0);
    csr_chk("R7 mask", 7'd3);
    chk("R7 mask value", rdata, 16'h3F00);
    csr_wr(7'd3, 16'h0000, 5'h0);

    // R8 test register locked
    csr_wr(7'd124, 16'h0001, 5'h0);
    chk("R8 locked runt", runt, 0);
    csr_chk("R8 locked read", 7'd124);
    csr_wr(7'd4, 16'h0001, 5'h0);
    csr_wr(7'd124, 16'h0001, 5'h0);
    chk("R8 unlocked runt", runt, 1);
    csr_wr(7'd4, 16'h0000, 5'h0);
    csr_wr(7'd124, 16'h0000, 5'h0);
    chk("R8 relocked runt", runt, 1);

    // R5 init and start together
    csr_wr(7'd15, 16'hA5C3, 5'h0);
    csr_wr(7'd0, 16'h0003, 5'h0);
    chk("R5 init_req", init_req, 1);
    chk("R5 tx_en", tx_en, 1);
    chk("R5 rx_en", rx_en, 1);
    csr_chk("R5 ctl", 7'd0);
    chk("R5 ctl value", rdata, 16'h201A);

    // R6 interrupt gating
    csr_wr(7'd0, 16'h2040, 5'h08);
    idle(1);
    chk("R6 irq on", irq, 1);
    csr_wr(7'd3, 16'h0800, 5'h0);
    idle(1);
    chk("R6 irq masked", irq, 0);
    csr_wr(7'd3, 16'h0000, 5'h0);

    // R10 clear with the source active on the same edge
    csr_wr(7'd0, 16'h0840, 5'h08);
    csr_chk("R10 set wins", 7'd0);
    idle(1);
    chk("R10 irq kept", irq, 1);
    csr_wr(7'd0, 16'h0840, 5'h00);
    csr_chk("R10 cleared", 7'd0);
    chk("R10 bit gone", rdata[11], 0);

    // R4 stop clears status, keeps configuration
    csr_wr(7'd0, 16'h0040, 5'h1F);
    csr_wr(7'd0, 16'h0044, 5'h0);
    chk("R4 ptr_rst", ptr_rst, 1);
    chk("R4 tx_en", tx_en, 0);
    chk("R4 mode kept", mode, 16'hA5C3);
    chk("R9 runt kept by stop", runt, 1);
    csr_chk("R4 ctl", 7'd0);
    chk("R4 ctl value", rdata, 16'h0044);
    xact(0, 1, 6'h12, 16'h0, 5'h0);
    chk("R1 addr after stop", rdata, 16'h0000);

    // R11 unimplemented numbers
    csr_wr(7'd50, 16'hFFFF, 5'h0);
    csr_chk("R11 csr 50", 7'd50);
    xact(1, 0, 6'h12, 16'h0009, 5'h0);
    xact(1, 0, 6'h16, 16'hBEEF, 5'h0);
    xact(0, 1, 6'h16, 16'h0, 5'h0);
    chk("R11 cfg 9", rdata, 16'h0000);

    // R2 two groups behind one number
    xact(1, 0, 6'h12, 16'h0002, 5'h0);
    xact(1, 0, 6'h16, 16'h1357, 5'h0);
    xact(0, 1, 6'h16, 16'h0, 5'h0);
    chk("R2 cfg 2", rdata, 16'h1357);
    xact(0, 1, 6'h10, 16'h0, 5'h0);
    chk("R2 csr 2", rdata, 16'h0000);
    chk("R2 cfg port out", cfg[47:32], 16'h1357);

    // R9 hardware reset clears runt accept
    hw_reset();
    #1;
    chk("R9 runt after reset", runt, 0);

    // R3 soft reset by a single read
    csr_wr(7'd15, 16'h7E81, 5'h0);
    csr_wr(7'd0, 16'h0002, 5'h0);
    xact(0, 1, 6'h20, 16'h0, 5'h0);
    chk("R3 pulse", srst, 1);
    idle(1);
    mreset();
    chk("R3 pulse ends", srst, 0);
    chk("R3 mode", mode, 16'h0000);
    chk("R3 tx_en", tx_en, 0);
    xact(0, 1, 6'h12, 16'h0, 5'h0);
    chk("R3 addr kept", rdata, 16'h0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 8)
        0: csr_wr(7'd15, 16'($urandom), 5'h0);
        1: begin
          xact(1, 0, 6'h12, 16'($urandom % 10), 5'h0);
          xact(1, 0, 6'h16, 16'($urandom), 5'h0);
        end
        2: csr_wr(7'd3, 16'($urandom), 5'($urandom));
        3: begin
          d = 16'($urandom);
          if ($urandom % 8 != 0) d[2] = 1'b0;
          csr_wr(7'd0, d, 5'($urandom));
          idle(1);
          chk("R6 R10 random irq", irq, mpend());
        end
        4: csr_chk("R10 random ctl", 7'd0);
        5: csr_chk("R2 random mode", 7'd15);
        6: begin
          ix = 7'($urandom % 10);
          xact(1, 0, 6'h12, {9'b0, ix}, 5'h0);
          xact(0, 1, 6'h16, 16'h0, 5'h0);
          chk("R2 random cfg", rdata, (ix < 7'd8) ? m_cfg[ix[2:0]] : 16'h0);
        end
        default: csr_chk("R7 random mask", 7'd3);
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule